// File: doc/BRIEF.md
# Cursor Register Shadow Bank with Update Arming

This block holds the four registers that steer a hardware cursor plane: control, position, base address and partial height. Software writes them over a simple write bus. Each write lands in a pending copy. The active copies feed the cursor fetch engine, and they change only at a vertical-blank strobe, and only when an update has been armed. This keeps the cursor shape, location and memory source consistent within one frame.

Arming follows write-order rules. A base-address write arms an update. A control write arms an update only when it turns on a cursor that is currently off. Any other write cancels an armed update that has not yet been applied. The one exception: a position write does not cancel an arm that came from a control-enable write.

The active position is also given in two's complement form. The active partial-height field is also given as a line count. A single status output reports whether the cursor is on.

Top module: `cursor_shadow_bank`

## Requirements
- R1: After reset, all active copies are zero, `cursor_on` is 0, `part_en` is 0, `part_lines` is 0, and no update is armed.
- R2: The write address selects the register: 0 control, 1 position, 2 base, 3 partial height. A write changes only the pending copy. Active outputs do not change on the write.
- R3: A base write arms an update. At the next `vblank` pulse, all four pending copies move to the active copies in that same cycle, and the arm clears. A later `vblank` with no new arm copies nothing.
- R4: A control write arms an update when the active control mode field (bits [2:0]) is zero and the written mode field is non-zero.
- R5: A control write that does not enable the cursor cancels a pending arm. So does any partial-height write.
- R6: A position write cancels an arm made by a base write. It keeps an arm made by a control-enable write. A position write alone never arms.
- R7: A `vblank` pulse with no armed update leaves every active copy unchanged.
- R8: A write in the same cycle as `vblank` takes effect after the latch. The latch copies the earlier pending values. The arm decision for that write, including the control enable test, uses the active values as they stand after the latch.
- R9: Position is sign-magnitude. X magnitude is in bits [11:0] with its sign in bit 15. Y magnitude is in bits [27:16] with its sign in bit 31. `cur_x` and `cur_y` give the active values in two's complement.
- R10: Partial height: bit 31 is the enable and bits [7:0] hold height minus one. `part_lines` equals field+1 when enabled and 0 when not. `part_en` mirrors the enable bit.
- R11: `cursor_on` is 1 exactly when the active control mode field is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| vblank | input | 1 | One-cycle vertical-blank strobe |
| act_ctrl | output | 32 | Active control word |
| act_pos | output | 32 | Active position word (raw) |
| act_base | output | 32 | Active base address |
| act_size | output | 32 | Active partial-height word |
| cur_x | output | 13 | Active X, two's complement |
| cur_y | output | 13 | Active Y, two's complement |
| part_en | output | 1 | Partial height enabled |
| part_lines | output | 9 | Cursor line count when partial height is on, else 0 |
| cursor_on | output | 1 | Cursor enabled status |

## Verification
The bench builds the block with its defaults: 32-bit words, 12-bit position magnitudes, a 3-bit mode field and an 8-bit height field. With these values, both sign bits, the largest line count and every arm and cancel path are reachable from the write bus. The widths are small enough that each pending and active value can be written out as a literal in the bench. Both orderings of a write with respect to `vblank` are covered, including the same-cycle control write whose enable test depends on the value just latched.

// File: rtl/cursor_shadow_pkg.sv
package cursor_shadow_pkg;

    localparam int NUM_REGS = 4;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_POS  = 2'd1,
        REG_BASE = 2'd2,
        REG_SIZE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ARM_NONE   = 2'd0,
        ARM_BASE   = 2'd1,
        ARM_ENABLE = 2'd2
    } arm_kind_e;

    // Sign-magnitude field to two's complement.
    function automatic logic [12:0] sm_to_tc(input logic sign, input logic [11:0] mag);
        logic [12:0] ext;
        ext = {1'b0, mag};
        return sign ? (~ext + 13'd1) : ext;
    endfunction

endpackage

// File: rtl/cursor_arm_ctrl.sv
module cursor_arm_ctrl
    import cursor_shadow_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  reg_sel_e wr_sel,
    input  logic     wr_mode_on,
    input  logic     act_mode_on,
    input  logic     pend_mode_on,
    input  logic     vblank,
    output logic     load
);

    arm_kind_e kind_q, kind_d, kind_post;
    logic      mode_after_latch;

    always_comb begin
        load             = vblank && (kind_q != ARM_NONE);
        mode_after_latch = load ? pend_mode_on : act_mode_on;
        kind_post        = load ? ARM_NONE : kind_q;
        kind_d           = kind_post;
        if (wr_en) begin
            unique case (wr_sel)
                REG_BASE: kind_d = ARM_BASE;
                REG_CTRL: kind_d = (!mode_after_latch && wr_mode_on) ? ARM_ENABLE : ARM_NONE;
                REG_POS:  kind_d = (kind_post == ARM_ENABLE) ? ARM_ENABLE : ARM_NONE;
                default:  kind_d = ARM_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) kind_q <= ARM_NONE;
        else     kind_q <= kind_d;
    end

    // R3
    base_arms_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == REG_BASE) |=> (kind_q == ARM_BASE));

    // R5
    size_cancels_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == REG_SIZE) |=> (kind_q == ARM_NONE));

    // R3
    load_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !wr_en) |=> (kind_q == ARM_NONE));

    // R6
    enable_survives_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_q == ARM_ENABLE && !vblank && wr_en && wr_sel == REG_POS) |=> (kind_q == ARM_ENABLE));

endmodule

// File: rtl/cursor_reg_bank.sv
module cursor_reg_bank
    import cursor_shadow_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREG   = NUM_REGS,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        load,
    output logic [NREG-1:0][DATA_W-1:0] pend,
    output logic [NREG-1:0][DATA_W-1:0] act
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Latch reads the pending value from before this cycle's write.
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i] <= '0;
                act[i]  <= '0;
            end else begin
                if (load)                                  act[i]  <= pend[i];
                if (wr_en && wr_idx == IDX_W'(i))          pend[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/cursor_pos_decode.sv
module cursor_pos_decode
    import cursor_shadow_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MAG_W  = 12,
    localparam int HALF  = DATA_W / 2
) (
    input  logic [DATA_W-1:0] pos_word,
    output logic [MAG_W:0]    x_tc,
    output logic [MAG_W:0]    y_tc
);

    logic [MAG_W:0] x_ext, y_ext;

    always_comb begin
        x_ext = {1'b0, pos_word[MAG_W-1:0]};
        y_ext = {1'b0, pos_word[HALF+MAG_W-1:HALF]};
        x_tc  = pos_word[HALF-1]   ? (~x_ext + 1'b1) : x_ext;
        y_tc  = pos_word[DATA_W-1] ? (~y_ext + 1'b1) : y_ext;
    end

endmodule

// File: rtl/cursor_shadow_bank.sv
module cursor_shadow_bank
    import cursor_shadow_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MAG_W    = 12,
    parameter int MODE_W   = 3,
    parameter int HEIGHT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                vblank,
    output logic [DATA_W-1:0]   act_ctrl,
    output logic [DATA_W-1:0]   act_pos,
    output logic [DATA_W-1:0]   act_base,
    output logic [DATA_W-1:0]   act_size,
    output logic [MAG_W:0]      cur_x,
    output logic [MAG_W:0]      cur_y,
    output logic                part_en,
    output logic [HEIGHT_W:0]   part_lines,
    output logic                cursor_on
);

    logic [NUM_REGS-1:0][DATA_W-1:0] pend, act;
    logic load;

    cursor_arm_ctrl u_arm (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_sel       (reg_sel_e'(wr_addr)),
        .wr_mode_on   (|wr_data[MODE_W-1:0]),
        .act_mode_on  (|act[REG_CTRL][MODE_W-1:0]),
        .pend_mode_on (|pend[REG_CTRL][MODE_W-1:0]),
        .vblank       (vblank),
        .load         (load)
    );

    cursor_reg_bank #(.DATA_W(DATA_W), .NREG(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .pend    (pend),
        .act     (act)
    );

    cursor_pos_decode #(.DATA_W(DATA_W), .MAG_W(MAG_W)) u_pos (
        .pos_word (act[REG_POS]),
        .x_tc     (cur_x),
        .y_tc     (cur_y)
    );

    always_comb begin
        act_ctrl   = act[REG_CTRL];
        act_pos    = act[REG_POS];
        act_base   = act[REG_BASE];
        act_size   = act[REG_SIZE];
        cursor_on  = |act[REG_CTRL][MODE_W-1:0];
        part_en    = act[REG_SIZE][DATA_W-1];
        part_lines = part_en ? ({1'b0, act[REG_SIZE][HEIGHT_W-1:0]} + 1'b1) : '0;
    end

    // R7
    hold_base_chk: assert property (@(posedge clk) disable iff (rst)
        !vblank |=> $stable(act_base));

    // R7
    hold_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        !vblank |=> ($stable(act_ctrl) && $stable(cursor_on)));

    // R2
    pending_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !vblank) |=> $stable(act_pos));

endmodule

// File: tb/cursor_shadow_bank_test.sv
`timescale 1ns/1ps
module cursor_shadow_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        vblank = 1'b0;
    logic [31:0] act_ctrl, act_pos, act_base, act_size;
    logic [12:0] cur_x, cur_y;
    logic        part_en, cursor_on;
    logic [8:0]  part_lines;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [1:0] A_CTRL = 2'd0, A_POS = 2'd1, A_BASE = 2'd2, A_SIZE = 2'd3;
    localparam logic [31:0] P1 = (32'd1 << 15) | 32'd5 | (32'd300 << 16);
    localparam logic [31:0] P2 = (32'd1 << 31) | (32'd9 << 16) | 32'd12;

    always #2.5 clk = ~clk;

    cursor_shadow_bank uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vblank(vblank), .act_ctrl(act_ctrl), .act_pos(act_pos), .act_base(act_base),
        .act_size(act_size), .cur_x(cur_x), .cur_y(cur_y), .part_en(part_en),
        .part_lines(part_lines), .cursor_on(cursor_on)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    // One bus cycle; returns at the following falling edge.
    task automatic cyc(input logic en, input logic [1:0] a, input logic [31:0] d, input logic vb);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; vblank = vb;
        @(negedge clk);
        wr_en = 1'b0; vblank = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic vb();
        cyc(1'b0, 2'd0, 32'd0, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1", "ctrl", act_ctrl, 0);
        chk("R1", "pos", act_pos, 0);
        chk("R1", "base", act_base, 0);
        chk("R1", "size", act_size, 0);
        chk("R1", "on", {31'd0, cursor_on}, 0);
        chk("R1", "lines", {23'd0, part_lines}, 0);
        vb();
        chk("R1", "no arm after reset", act_base, 0);
    endtask

    task automatic t_base_arm();
        wr(A_SIZE, 32'h8000_0007);
        wr(A_BASE, 32'h1000);
        chk("R2", "base pending only", act_base, 0);
        chk("R2", "size pending only", act_size, 0);
        vb();
        chk("R3", "base latched", act_base, 32'h1000);
        chk("R3", "size latched same cycle", act_size, 32'h8000_0007);
        chk("R10", "part_en", {31'd0, part_en}, 1);
        chk("R10", "lines", {23'd0, part_lines}, 8);
        wr(A_POS, 32'd7);
        vb();
        chk("R6", "pos alone no arm", act_pos, 0);
        wr(A_BASE, 32'h1000);
        vb();
        chk("R3", "pos after base arm", act_pos, 32'd7);
    endtask

    task automatic t_enable();
        wr(A_CTRL, 32'h2);
        chk("R4", "ctrl pending", act_ctrl, 0);
        vb();
        chk("R4", "enable arms", act_ctrl, 32'h2);
        chk("R11", "on", {31'd0, cursor_on}, 1);
    endtask

    task automatic t_ctrl_no_enable();
        wr(A_CTRL, 32'h5);
        vb();
        chk("R5", "ctrl no arm when on", act_ctrl, 32'h2);
        wr(A_BASE, 32'h2000);
        wr(A_CTRL, 32'h5);
        vb();
        chk("R5", "ctrl cancels base arm", act_base, 32'h1000);
    endtask

    task automatic t_size_cancel();
        wr(A_BASE, 32'h3000);
        wr(A_SIZE, 32'h0000_0002);
        vb();
        chk("R5", "size cancels", act_base, 32'h1000);
    endtask

    task automatic t_pos_cancel();
        wr(A_BASE, 32'h4000);
        wr(A_POS, P1);
        vb();
        chk("R6", "pos cancels base arm", act_base, 32'h1000);
        wr(A_CTRL, 32'h0);
        wr(A_BASE, 32'h4000);
        vb();
        chk("R11", "disabled", {31'd0, cursor_on}, 0);
        chk("R9", "x neg", 32'($signed(cur_x)), 32'(-5));
        chk("R9", "y pos", 32'($signed(cur_y)), 32'd300);
        chk("R10", "size disabled lines", {23'd0, part_lines}, 0);
    endtask

    task automatic t_enable_covers_pos();
        wr(A_CTRL, 32'h1);
        wr(A_POS, P2);
        vb();
        chk("R6", "enable arm kept", act_pos, P2);
        chk("R9", "x pos", 32'($signed(cur_x)), 32'd12);
        chk("R9", "y neg", 32'($signed(cur_y)), 32'(-9));
        chk("R4", "ctrl", act_ctrl, 32'h1);
    endtask

    task automatic t_hold();
        vb();
        chk("R7", "base hold", act_base, 32'h4000);
        chk("R7", "ctrl hold", act_ctrl, 32'h1);
    endtask

    task automatic t_same_cycle();
        wr(A_BASE, 32'h5000);
        cyc(1'b1, A_BASE, 32'h6000, 1'b1);
        chk("R8", "old pending latched", act_base, 32'h5000);
        vb();
        chk("R8", "write armed after latch", act_base, 32'h6000);
        wr(A_CTRL, 32'h0);
        wr(A_BASE, 32'h6000);
        cyc(1'b1, A_CTRL, 32'h3, 1'b1);
        chk("R8", "ctrl off latched", act_ctrl, 0);
        vb();
        chk("R8", "enable test uses post-latch mode", act_ctrl, 32'h3);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_base_arm();
        t_enable();
        t_ctrl_no_enable();
        t_size_cancel();
        t_pos_cancel();
        t_enable_covers_pos();
        t_hold();
        t_same_cycle();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule